// File: doc/BRIEF.md
# Synchronous Serial Master Receiver

This block receives words on a half-duplex synchronous serial link on which it is the clock master. A programmable divider times a shift clock that the block drives out on `sck_o`. On each bit the block samples the data line `sdi_i`, least-significant bit first. Words are eight bits wide, or nine when the extra bit is enabled. The clock pin and the data pin each have their own polarity-inversion control.

There are two ways to run reception. A one-shot request (`single_start`) arms the receiver for exactly one word and clears itself when that word completes. A level enable (`cont_en`) makes the receiver take words back to back until the enable drops. When both are active, the level enable wins.

Completed words go into a two-entry receive buffer. `rx_done` stays high while the buffer holds data, and `rx_irq` copies it when interrupts are enabled. A read strobe pops the head entry. A word that completes while the buffer is full and no pop happens in the same cycle is dropped. The drop raises `ovr_err` and halts reception until the continuous enable is taken low.

Top module: `sync_rx_master`

## Requirements
- R1: The shift clock toggles only while `sync_en` is high, at least one of `cont_en` or the armed one-shot is active, and `ovr_err` is low. In any other case, from the next cycle on, `sck_o` sits at its idle level.
- R2: A `single_start` pulse sets `single_armed`. The receiver then takes exactly one word, clears `single_armed` in the cycle that word completes, and issues no further clock edges.
- R3: With `cont_en` high, words are taken one after another with a one-cycle gap between them. Dropping `cont_en` partway through a word throws that partial word away.
- R4: With both `cont_en` and the one-shot armed, reception is continuous and goes on past the first word.
- R5: A half bit lasts (D+1)×2 system clocks, so a full bit lasts (D+1)×4. D is `div_val[7:0]` when `wide_div` is 0 and the whole `div_val[15:0]` when `wide_div` is 1.
- R6: The idle level of `sck_o` is high when `clk_inv` is 0 and low when `clk_inv` is 1. Each bit is sampled at the transition of `sck_o` away from its idle level, LSB first, into `rx_data[0]` upward.
- R7: When `dat_inv` is 1, every sampled bit is inverted before it is stored.
- R8: When `ninth_en` is 1, a word has nine bits and the last one appears on `rx_bit8`. When `ninth_en` is 0, a word has eight bits and `rx_bit8` reads 0.
- R9: The buffer holds two words. `rx_done` is high exactly while the buffer is not empty. `rd_strobe` pops the head entry. `rx_irq` equals `rx_done` gated by `rx_ie`.
- R10: A word that completes while the buffer is full, with no pop in the same cycle, is discarded. It sets `ovr_err` and halts reception, and the two stored words are kept. A pop in the same cycle as a completion stores the new word without error.
- R11: `ovr_err` reads 0 in the cycle after any cycle in which `cont_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_en | input | 1 | Port enabled as synchronous clock master |
| single_start | input | 1 | One-cycle pulse that arms one-word reception |
| cont_en | input | 1 | Continuous reception enable; low clears overrun |
| wide_div | input | 1 | 1 selects the full 16-bit divider |
| div_val | input | 16 | Divider value D |
| ninth_en | input | 1 | Nine-bit words |
| clk_inv | input | 1 | Invert the clock pin |
| dat_inv | input | 1 | Invert the data pin |
| rx_ie | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Pop the head of the receive buffer |
| sdi_i | input | 1 | Serial data in |
| sck_o | output | 1 | Shift clock out |
| rx_data | output | 8 | Low eight bits of the head word |
| rx_bit8 | output | 1 | Ninth bit of the head word |
| rx_done | output | 1 | Buffer not empty |
| rx_irq | output | 1 | Receive interrupt |
| ovr_err | output | 1 | Overrun error |
| single_armed | output | 1 | One-shot request pending |

## Verification
A word can complete into a full buffer in the same cycle that a read strobe pops it. This case decides whether the word is stored or counted as an overrun. The bench fills both entries in continuous mode without reading. It then times a single-cycle read to land on the exact edge where the third word completes, counted from the last sampling edge plus one half bit. The outcome is correct when `ovr_err` stays low and the buffer then returns the second and third words in order.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int WORD_W = 8;
  localparam int IDX_W  = $clog2(WORD_W + 2);
  typedef logic [WORD_W:0] rx_word_t;
endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
  parameter int DIV_W = 16,
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wide,
  input  logic [DIV_W-1:0] div_val,
  output logic             half_tick
);
  localparam int CW = DIV_W + 2;

  logic [CW-1:0] sel, half_len, cnt_q, cnt_d;

  always_comb begin
    sel       = wide ? CW'(div_val) : CW'(div_val[LOW_W-1:0]);
    half_len  = (sel + CW'(1)) << 1;
    half_tick = run && (cnt_q >= half_len - CW'(1));
    cnt_d     = (!run || half_tick) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/srx_shift.sv
module srx_shift
  import sync_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     go,
  input  logic     half_tick,
  input  logic     ninth_en,
  input  logic     sdi_eff,
  output logic     active,
  output logic     sck_low,
  output logic     word_done,
  output rx_word_t word_out
);
  logic             active_q, active_d, phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d, nbits;
  rx_word_t         sh_q, sh_d;

  always_comb begin
    nbits     = ninth_en ? IDX_W'(WORD_W + 1) : IDX_W'(WORD_W);
    active_d  = active_q;
    phase_d   = phase_q;
    idx_d     = idx_q;
    sh_d      = sh_q;
    word_done = 1'b0;
    if (!go) begin
      active_d = 1'b0;
      phase_d  = 1'b0;
      idx_d    = '0;
    end else if (!active_q) begin
      active_d = 1'b1;
      phase_d  = 1'b0;
      idx_d    = '0;
      sh_d     = '0;
    end else if (half_tick) begin
      if (!phase_q) begin
        phase_d     = 1'b1;
        sh_d[idx_q] = sdi_eff;
        idx_d       = idx_q + IDX_W'(1);
      end else begin
        phase_d = 1'b0;
        if (idx_q == nbits) begin
          word_done = 1'b1;
          active_d  = 1'b0;
          idx_d     = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
    end else begin
      active_q <= active_d;
      phase_q  <= phase_d;
      idx_q    <= idx_d;
      sh_q     <= sh_d;
    end
  end

  assign active   = active_q;
  assign sck_low  = active_q & phase_q;
  assign word_out = sh_q;
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import sync_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  logic     pop,
  input  rx_word_t din,
  output rx_word_t dout,
  output logic     not_empty,
  output logic     full,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rx_word_t        mem_q [DEPTH];
  logic [AW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    do_pop  = pop && (cnt_q != '0);
    do_push = push && ((cnt_q != CW'(DEPTH)) || do_pop);
    wr_d    = do_push ? bump(wr_q) : wr_q;
    rd_d    = do_pop  ? bump(rd_q) : rd_q;
    cnt_d   = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= din;
  end

  assign dout      = mem_q[rd_q];
  assign not_empty = (cnt_q != '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign level     = cnt_q;
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master
  import sync_rx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int LOW_W = 8,
  parameter int DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_en,
  input  logic                single_start,
  input  logic                cont_en,
  input  logic                wide_div,
  input  logic [DIV_W-1:0]    div_val,
  input  logic                ninth_en,
  input  logic                clk_inv,
  input  logic                dat_inv,
  input  logic                rx_ie,
  input  logic                rd_strobe,
  input  logic                sdi_i,
  output logic                sck_o,
  output logic [WORD_W-1:0]   rx_data,
  output logic                rx_bit8,
  output logic                rx_done,
  output logic                rx_irq,
  output logic                ovr_err,
  output logic                single_armed
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic     armed_q, armed_d, ovr_q, ovr_d;
  logic     go, half_tick, active, sck_low, word_done;
  logic     fifo_full, not_empty, push, pop, ovr_set;
  rx_word_t word_out, head;
  logic [LVL_W-1:0] fifo_level;

  assign go = sync_en & (cont_en | armed_q) & ~ovr_q;

  srx_baud #(.DIV_W(DIV_W), .LOW_W(LOW_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .run(active), .wide(wide_div),
    .div_val(div_val), .half_tick(half_tick)
  );

  srx_shift shift_i (
    .clk(clk), .rst_n(rst_n), .go(go), .half_tick(half_tick),
    .ninth_en(ninth_en), .sdi_eff(sdi_i ^ dat_inv), .active(active),
    .sck_low(sck_low), .word_done(word_done), .word_out(word_out)
  );

  srx_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(word_out),
    .dout(head), .not_empty(not_empty), .full(fifo_full), .level(fifo_level)
  );

  always_comb begin
    pop     = rd_strobe & not_empty;
    push    = word_done & (~fifo_full | pop);
    ovr_set = word_done & fifo_full & ~pop;
    armed_d = armed_q;
    if (single_start) armed_d = 1'b1;
    if (word_done)    armed_d = 1'b0;
    ovr_d   = cont_en ? (ovr_q | ovr_set) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      ovr_q   <= ovr_d;
    end
  end

  assign sck_o        = ~sck_low ^ clk_inv;
  assign rx_data      = head[WORD_W-1:0];
  assign rx_bit8      = head[WORD_W];
  assign rx_done      = not_empty;
  assign rx_irq       = not_empty & rx_ie;
  assign ovr_err      = ovr_q;
  assign single_armed = armed_q;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DEPTH = 2,
  parameter int LVL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_en,
  input logic             cont_en,
  input logic             clk_inv,
  input logic             sck_o,
  input logic             rd_strobe,
  input logic             rx_done,
  input logic             ovr_err,
  input logic             single_armed,
  input logic             word_done,
  input logic             fifo_full,
  input logic [LVL_W-1:0] level
);
  // R1
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> (sck_o != clk_inv));

  // R11
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cont_en |=> !ovr_err);

  // R10
  ovr_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $past(fifo_full && word_done && !rd_strobe));

  // R9
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_done) |-> $past(rd_strobe));

  // R2
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(single_armed) |-> $past(word_done));

  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
endmodule

bind sync_rx_master srx_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .cont_en(cont_en),
  .clk_inv(clk_inv), .sck_o(sck_o), .rd_strobe(rd_strobe),
  .rx_done(rx_done), .ovr_err(ovr_err), .single_armed(single_armed),
  .word_done(word_done), .fifo_full(fifo_full), .level(fifo_level)
);

// File: tb/sync_rx_master_tb.sv
module sync_rx_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sync_en, single_start, cont_en, wide_div, ninth_en;
  logic        clk_inv, dat_inv, rx_ie, rd_strobe;
  logic [15:0] div_val;
  logic        sdi_i, sck_o, rx_bit8, rx_done, rx_irq, ovr_err, single_armed;
  logic [7:0]  rx_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int bitptr = 0;
  int last_edge = 0;
  int last_period = 0;
  logic [8:0] words [0:15];

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  sync_rx_master dut_i (
    .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .single_start(single_start),
    .cont_en(cont_en), .wide_div(wide_div), .div_val(div_val),
    .ninth_en(ninth_en), .clk_inv(clk_inv), .dat_inv(dat_inv), .rx_ie(rx_ie),
    .rd_strobe(rd_strobe), .sdi_i(sdi_i), .sck_o(sck_o), .rx_data(rx_data),
    .rx_bit8(rx_bit8), .rx_done(rx_done), .rx_irq(rx_irq), .ovr_err(ovr_err),
    .single_armed(single_armed)
  );

  // slave: present the current bit; advance after each sampling edge
  always @(sck_o) begin
    if (rst_n === 1'b1 && sck_o === clk_inv) begin
      bitptr++;
      last_period = cyc - last_edge;
      last_edge = cyc;
    end
  end

  always_comb begin
    int nb;
    nb = ninth_en ? 9 : 8;
    sdi_i = words[(bitptr / nb) % 16][bitptr % nb] ^ dat_inv;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_words(input logic [8:0] w0, input logic [8:0] w1, input logic [8:0] w2);
    for (int i = 0; i < 16; i++) words[i] = 9'($urandom);
    words[0] = w0; words[1] = w1; words[2] = w2;
    bitptr = 0;
  endtask

  task automatic pulse_single();
    @(negedge clk) single_start = 1'b1;
    @(negedge clk) single_start = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [8:0] w);
    wait (rx_done === 1'b1);
    @(negedge clk);
    chk(req, rx_data, w[7:0]);
    chk(req, rx_bit8, ninth_en ? w[8] : 1'b0);
    rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; sync_en = 0; single_start = 0; cont_en = 0; wide_div = 0;
    ninth_en = 0; clk_inv = 0; dat_inv = 0; rx_ie = 0; rd_strobe = 0;
    div_val = 16'd2;
    void'($urandom(32'd7391));
    load_words(9'h0, 9'h0, 9'h0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset done", rx_done, 0);
    chk("R9 reset irq", rx_irq, 0);
    chk("R10 reset ovr", ovr_err, 0);
    chk("R6 idle high", sck_o, 1);

    // R1: port disabled, no clocking
    cont_en = 1'b1;
    repeat (60) @(negedge clk);
    chk("R1 no edges", bitptr, 0);
    chk("R1 no word", rx_done, 0);
    cont_en = 1'b0;
    sync_en = 1'b1;

    // R2 / R5 single word, 8-bit divider 2 -> 12 cycles per bit
    rx_ie = 1'b1;
    load_words(9'h0A5, 9'h13C, 9'h055);
    pulse_single();
    chk("R2 armed", single_armed, 1);
    wait (rx_done === 1'b1);
    @(negedge clk);
    chk("R9 irq", rx_irq, 1);
    chk("R2 armed cleared", single_armed, 0);
    chk("R5 period 8-bit", last_period, 12);
    read_check("R2", 9'h0A5);
    repeat (100) @(negedge clk);
    chk("R2 clock stopped", bitptr, 8);
    chk("R9 empty after pop", rx_done, 0);

    // R5 16-bit divider 0x103 -> 1040; then same value in 8-bit mode -> 16
    wide_div = 1'b1; div_val = 16'h0103;
    load_words(9'h0C3, 9'h0, 9'h0);
    pulse_single();
    read_check("R5", 9'h0C3);
    chk("R5 period 16-bit", last_period, 1040);
    wide_div = 1'b0;
    load_words(9'h03F, 9'h0, 9'h0);
    pulse_single();
    read_check("R5", 9'h03F);
    chk("R5 low byte only", last_period, 16);

    // R7 data inversion, R8 ninth bit
    div_val = 16'd1;
    dat_inv = 1'b1;
    load_words(9'h05A, 9'h0, 9'h0);
    pulse_single();
    read_check("R7", 9'h05A);
    dat_inv = 1'b0;
    ninth_en = 1'b1;
    load_words(9'h1C3, 9'h0, 9'h0);
    pulse_single();
    read_check("R8 nine", 9'h1C3);
    ninth_en = 1'b0;
    load_words(9'h1F0, 9'h0, 9'h0);
    pulse_single();
    read_check("R8 eight", 9'h0F0);

    // R6 inverted clock idles low
    @(negedge clk) clk_inv = 1'b1;
    @(negedge clk);
    chk("R6 idle low", sck_o, 0);
    load_words(9'h081, 9'h0, 9'h0);
    pulse_single();
    read_check("R6", 9'h081);
    clk_inv = 1'b0;

    // R3 continuous, random settings
    for (int it = 0; it < 4; it++) begin
      @(negedge clk);
      div_val = 16'($urandom_range(0, 3));
      ninth_en = 1'($urandom);
      clk_inv = 1'($urandom);
      dat_inv = 1'($urandom);
      rx_ie = 1'($urandom);
      @(negedge clk);
      load_words(9'($urandom), 9'($urandom), 9'($urandom));
      cont_en = 1'b1;
      for (int k = 0; k < 4; k++) read_check("R3", words[k]);
      cont_en = 1'b0;
      repeat (80) @(negedge clk);
      chk("R3 partial dropped", rx_done, 0);
    end
    ninth_en = 0; clk_inv = 0; dat_inv = 0; rx_ie = 0;

    // R4 both enables
    @(negedge clk);
    load_words(9'h011, 9'h022, 9'h033);
    @(negedge clk) begin single_start = 1'b1; cont_en = 1'b1; end
    @(negedge clk) single_start = 1'b0;
    read_check("R4", 9'h011);
    chk("R4 armed cleared", single_armed, 0);
    read_check("R4", 9'h022);
    read_check("R4", 9'h033);
    cont_en = 1'b0;
    repeat (80) @(negedge clk);
    chk("R9 irq off", rx_irq, 0);

    // R10 overrun, R11 clear
    div_val = 16'd0;
    load_words(9'h0E1, 9'h0E2, 9'h0E3);
    @(negedge clk) cont_en = 1'b1;
    wait (bitptr >= 24);
    repeat (10) @(negedge clk);
    chk("R10 overrun set", ovr_err, 1);
    begin
      int held;
      held = bitptr;
      repeat (100) @(negedge clk);
      chk("R10 blocked", bitptr, held);
    end
    cont_en = 1'b0;
    @(negedge clk);
    chk("R11 cleared", ovr_err, 0);
    read_check("R10", 9'h0E1);
    chk("R9 still pending", rx_done, 1);
    read_check("R10", 9'h0E2);
    chk("R9 drained", rx_done, 0);

    // R10 same-cycle completion and pop while full (H = 4)
    div_val = 16'd1;
    load_words(9'h0B1, 9'h0B2, 9'h0B3);
    @(negedge clk) cont_en = 1'b1;
    wait (bitptr == 24);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 head before pop", rx_data, 8'hB1);
    rd_strobe = 1'b1;
    @(negedge clk) begin rd_strobe = 1'b0; cont_en = 1'b0; end
    chk("R10 no overrun on pop", ovr_err, 0);
    read_check("R10", 9'h0B2);
    read_check("R10", 9'h0B3);
    chk("R10 buffer empty", rx_done, 0);

    summary();
    $finish;
  end
endmodule